// File: doc/BRIEF.md
# Zero-Suppressing Snippet Buffer

This block takes one channel's continuous stream of 12-bit samples, each with a timestamp, and stores only the stretches of waveform near a threshold crossing. Every stored stretch, or snippet, includes a set number of look-back samples from before the first crossing and a set number of trailing samples after the last one. Crossings that lie close together merge into a single snippet. Snippets are packed three samples to a 36-bit word in a circular word buffer.

Each snippet begins with a header word that holds its start timestamp, its sample count and a truncation flag. Software can use these to match snippets against an external trigger that fires at about 100 Hz. A readout engine drains the buffer one word per request. It sees a snippet only after the whole snippet has been written. When the free space cannot hold a worst-case snippet, a new snippet is discarded and counted. Data that has not been read is never overwritten.

Top module: `zs_snippet_buf`

## Requirements
- R1: A sample with valid high counts as over threshold when its unsigned value is greater than or equal to `thresh`. A value of `thresh - 1` does not trigger.
- R2: A snippet holds every sample from N_PRE samples before an over-threshold sample to N_POST samples after it. Windows that overlap or touch form one snippet. Any look-back position that falls before the first sample since reset reads as value 0 with timestamp 0.
- R3: Data words hold three samples each: the first in bits [11:0], the second in [23:12] and the third in [35:24]. The unused slots of a snippet's final word are zero.
- R4: Each snippet starts with a header word. Its bits [TS_W-1:0] hold the timestamp of the first sample. The next $clog2(MAX_LEN+1) bits hold the sample count, the bit above them is the truncation flag, and all remaining bits are zero.
- R5: A snippet that reaches MAX_LEN samples is closed with the truncation flag set. The next kept sample opens a new snippet.
- R6: If, when a snippet would open, the free words are fewer than 1 + ceil(MAX_LEN/3), the whole snippet is discarded and `drop_count` increments (saturating). The stored data is left unchanged. Once space is freed, later snippets are stored again.
- R7: `rd_avail` rises only when a snippet's header and all of its data are written. It stays low while a snippet is still open.
- R8: A read request (`rd_en`) while `rd_avail` is high returns the next word on `rd_data` one cycle later, with `rd_valid` high. Words come out in the order they were written. `rd_en` while `rd_avail` is low has no effect.
- R9: Input cycles with `s_valid` low are ignored, whatever `s_data` and `s_ts` carry.
- R10: After reset, `rd_avail`, `rd_valid` and `drop_count` are zero and the look-back history is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thresh | input | 12 | Unsigned trigger level |
| s_valid | input | 1 | Sample strobe |
| s_data | input | 12 | Sample value |
| s_ts | input | 24 | Sample timestamp |
| rd_en | input | 1 | Read request for one word |
| rd_avail | output | 1 | At least one committed word is unread |
| rd_valid | output | 1 | `rd_data` carries a word this cycle |
| rd_data | output | 36 | Header or packed data word |
| drop_count | output | 16 | Number of snippets discarded for lack of space |

## Verification
The hardest situation to reach is the drop decision. It needs a buffer that is nearly full of committed but unread snippets at the exact moment a new crossing arrives, and it then needs that space to come back after a drain. The bench shrinks the buffer to 16 words and MAX_LEN to 12. It sends six separated pulses without reading, so the fifth and sixth find only four free words. It then drains the buffer and sends one more pulse, which must be stored. A run of 20 over-threshold samples produces back-to-back truncated snippets, where a header write and a data write happen in the same cycle.

// File: rtl/zs_pkg.sv
package zs_pkg;
   function automatic int ceil_div(input int num, input int den);
      return (num + den - 1) / den;
   endfunction
endpackage

// File: rtl/zs_pre_window.sv
module zs_pre_window #(
   parameter int SW     = 12,
   parameter int TSW    = 24,
   parameter int N_PRE  = 3,
   parameter int N_POST = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           in_valid,
   input  logic [SW-1:0]  in_data,
   input  logic [TSW-1:0] in_ts,
   input  logic [SW-1:0]  thresh,
   output logic           keep,
   output logic [SW-1:0]  dly_data,
   output logic [TSW-1:0] dly_ts
);
   localparam int WIN = N_PRE + N_POST;
   localparam int HW  = $clog2(WIN + 2);

   logic          over;
   logic [HW-1:0] hold;

   assign over = in_data >= thresh;
   assign keep = over || (hold != '0);

   always_ff @(posedge clk) begin
      if (!rst_n)
         hold <= '0;
      else if (in_valid)
         hold <= over ? HW'(WIN) : ((hold != '0) ? hold - 1'b1 : '0);
   end

   generate
      if (N_PRE == 0) begin : g_direct
         assign dly_data = in_data;
         assign dly_ts   = in_ts;
      end else begin : g_line
         logic [SW-1:0]  line_d [N_PRE];
         logic [TSW-1:0] line_t [N_PRE];
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int i = 0; i < N_PRE; i++) begin
                  line_d[i] <= '0;
                  line_t[i] <= '0;
               end
            end else if (in_valid) begin
               line_d[0] <= in_data;
               line_t[0] <= in_ts;
               for (int i = 1; i < N_PRE; i++) begin
                  line_d[i] <= line_d[i-1];
                  line_t[i] <= line_t[i-1];
               end
            end
         end
         assign dly_data = line_d[N_PRE-1];
         assign dly_ts   = line_t[N_PRE-1];
      end
   endgenerate
endmodule

// File: rtl/zs_word_ram.sv
module zs_word_ram #(
   parameter int WW = 36,
   parameter int AW = 9
) (
   input  logic          clk,
   input  logic          we_a,
   input  logic [AW-1:0] addr_a,
   input  logic [WW-1:0] din_a,
   input  logic          we_b,
   input  logic [AW-1:0] addr_b,
   input  logic [WW-1:0] din_b,
   input  logic          re,
   input  logic [AW-1:0] raddr,
   output logic [WW-1:0] dout
);
   logic [WW-1:0] mem [2**AW];

   always_ff @(posedge clk) begin
      if (we_a) mem[addr_a] <= din_a;
      if (we_b) mem[addr_b] <= din_b;
      if (re)   dout <= mem[raddr];
   end
endmodule

// File: rtl/zs_framer.sv
module zs_framer
   import zs_pkg::*;
#(
   parameter int SW      = 12,
   parameter int TSW     = 24,
   parameter int PACK    = 3,
   parameter int MAX_LEN = 200,
   parameter int DEPTH   = 512,
   parameter int DROP_W  = 16,
   localparam int WW     = PACK * SW,
   localparam int AW     = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              v,
   input  logic              keep,
   input  logic [SW-1:0]     d_data,
   input  logic [TSW-1:0]    d_ts,
   input  logic [AW:0]       rd_ptr,
   output logic              we_a,
   output logic [AW-1:0]     addr_a,
   output logic [WW-1:0]     din_a,
   output logic              we_b,
   output logic [AW-1:0]     addr_b,
   output logic [WW-1:0]     din_b,
   output logic [AW:0]       wr_ptr,
   output logic [AW:0]       cm_ptr,
   output logic [DROP_W-1:0] drop_count
);
   localparam int LW    = $clog2(MAX_LEN + 1);
   localparam int SLW   = $clog2(PACK + 1);
   localparam int WORST = 1 + ceil_div(MAX_LEN, PACK);

   logic           open, skip;
   logic [LW-1:0]  len, new_len;
   logic [SLW-1:0] slot, slot_eff;
   logic [WW-1:0]  pack, pack_nx;
   logic [TSW-1:0] ts0;
   logic [AW-1:0]  hdr_addr;
   logic [AW:0]    used, data_ptr, wr_nx;
   logic           room, take, start, end_norm, end_trunc, word_full, storing;
   logic           wa_full, wa_tail;

   assign used      = wr_ptr - rd_ptr;
   assign room      = (DEPTH - int'(used)) >= WORST;
   assign take      = v && keep;
   assign start     = take && !open;
   assign end_norm  = v && !keep && open;
   assign new_len   = start ? LW'(1) : len + LW'(1);
   assign end_trunc = take && (new_len == LW'(MAX_LEN));
   assign slot_eff  = start ? '0 : slot;
   assign word_full = slot_eff == SLW'(PACK - 1);
   assign pack_nx   = (start ? '0 : pack) | (WW'(d_data) << (SW * slot_eff));
   assign storing   = start ? room : !skip;

   assign wa_full  = take && storing && (word_full || end_trunc);
   assign wa_tail  = end_norm && !skip && (slot != '0);
   assign data_ptr = wr_ptr + ((start && room) ? 1'b1 : 1'b0);
   assign we_a     = wa_full || wa_tail;
   assign addr_a   = data_ptr[AW-1:0];
   assign din_a    = wa_full ? pack_nx : pack;
   assign wr_nx    = data_ptr + (we_a ? 1'b1 : 1'b0);

   assign we_b   = storing && (end_trunc || end_norm);
   assign addr_b = start ? wr_ptr[AW-1:0] : hdr_addr;
   always_comb begin
      din_b = '0;
      din_b[TSW-1:0]   = start ? d_ts : ts0;
      din_b[TSW +: LW] = end_trunc ? new_len : len;
      din_b[TSW + LW]  = end_trunc;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         open <= 1'b0;  skip <= 1'b0;  len <= '0;  slot <= '0;  pack <= '0;
         ts0 <= '0;  hdr_addr <= '0;  wr_ptr <= '0;  cm_ptr <= '0;
         drop_count <= '0;
      end else begin
         wr_ptr <= wr_nx;
         if (we_b) cm_ptr <= wr_nx;
         if (start && !room && drop_count != '1) drop_count <= drop_count + 1'b1;
         if (take) begin
            open <= !end_trunc;
            len  <= new_len;
            if (word_full || end_trunc) begin
               slot <= '0;
               pack <= '0;
            end else begin
               slot <= slot_eff + 1'b1;
               pack <= pack_nx;
            end
            if (start) begin
               skip     <= !room;
               ts0      <= d_ts;
               hdr_addr <= wr_ptr[AW-1:0];
            end
         end else if (end_norm) begin
            open <= 1'b0;
            slot <= '0;
            pack <= '0;
         end
      end
   end
endmodule

// File: rtl/zs_snippet_buf.sv
module zs_snippet_buf
   import zs_pkg::*;
#(
   parameter int SAMPLE_W = 12,
   parameter int TS_W     = 24,
   parameter int PACK     = 3,
   parameter int N_PRE    = 8,
   parameter int N_POST   = 16,
   parameter int MAX_LEN  = 200,
   parameter int DEPTH    = 512,
   parameter int DROP_W   = 16,
   localparam int WW      = PACK * SAMPLE_W,
   localparam int AW      = $clog2(DEPTH),
   localparam int LEN_W   = $clog2(MAX_LEN + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [SAMPLE_W-1:0] thresh,
   input  logic                s_valid,
   input  logic [SAMPLE_W-1:0] s_data,
   input  logic [TS_W-1:0]     s_ts,
   input  logic                rd_en,
   output logic                rd_avail,
   output logic                rd_valid,
   output logic [WW-1:0]       rd_data,
   output logic [DROP_W-1:0]   drop_count
);
   if (DEPTH != 2**AW) begin : g_bad_depth
      $error("DEPTH must be a power of two");
   end
   if (DEPTH < 1 + ceil_div(MAX_LEN, PACK)) begin : g_bad_room
      $error("DEPTH cannot hold one worst-case snippet");
   end
   if (TS_W + LEN_W + 1 > WW) begin : g_bad_hdr
      $error("header fields do not fit one word");
   end
   if (MAX_LEN < 2 || PACK < 2) begin : g_bad_len
      $error("MAX_LEN and PACK must be at least 2");
   end

   logic                keep;
   logic [SAMPLE_W-1:0] dly_data;
   logic [TS_W-1:0]     dly_ts;
   logic                we_a, we_b;
   logic [AW-1:0]       addr_a, addr_b;
   logic [WW-1:0]       din_a, din_b;
   logic [AW:0]         wr_ptr, cm_ptr, rd_ptr;
   logic                re;

   zs_pre_window #(.SW(SAMPLE_W), .TSW(TS_W), .N_PRE(N_PRE), .N_POST(N_POST)) u_win (
      .clk(clk), .rst_n(rst_n), .in_valid(s_valid), .in_data(s_data), .in_ts(s_ts),
      .thresh(thresh), .keep(keep), .dly_data(dly_data), .dly_ts(dly_ts));

   zs_framer #(.SW(SAMPLE_W), .TSW(TS_W), .PACK(PACK), .MAX_LEN(MAX_LEN),
               .DEPTH(DEPTH), .DROP_W(DROP_W)) u_frm (
      .clk(clk), .rst_n(rst_n), .v(s_valid), .keep(keep), .d_data(dly_data),
      .d_ts(dly_ts), .rd_ptr(rd_ptr), .we_a(we_a), .addr_a(addr_a), .din_a(din_a),
      .we_b(we_b), .addr_b(addr_b), .din_b(din_b), .wr_ptr(wr_ptr), .cm_ptr(cm_ptr),
      .drop_count(drop_count));

   zs_word_ram #(.WW(WW), .AW(AW)) u_ram (
      .clk(clk), .we_a(we_a), .addr_a(addr_a), .din_a(din_a), .we_b(we_b),
      .addr_b(addr_b), .din_b(din_b), .re(re), .raddr(rd_ptr[AW-1:0]), .dout(rd_data));

   assign rd_avail = rd_ptr != cm_ptr;
   assign re       = rd_en && rd_avail;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_ptr   <= '0;
         rd_valid <= 1'b0;
      end else begin
         rd_valid <= re;
         if (re) rd_ptr <= rd_ptr + 1'b1;
      end
   end
endmodule

// File: rtl/zs_snippet_buf_chk.sv
module zs_snippet_buf_chk #(
   parameter int AW     = 9,
   parameter int DEPTH  = 512,
   parameter int DROP_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              s_valid,
   input logic              rd_en,
   input logic              rd_avail,
   input logic              rd_valid,
   input logic [DROP_W-1:0] drop_count,
   input logic [AW:0]       wr_ptr,
   input logic [AW:0]       cm_ptr,
   input logic [AW:0]       rd_ptr
);
   logic [AW:0] used_w, committed_w;
   assign used_w      = wr_ptr - rd_ptr;
   assign committed_w = cm_ptr - rd_ptr;

   // R6: writer never runs over unread words
   a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      int'(used_w) <= DEPTH);
   // R7: committed region never runs ahead of written region
   a_r7_commit_behind: assert property (@(posedge clk) disable iff (!rst_n)
      committed_w <= used_w);
   // R8: a granted read returns a word next cycle
   a_r8_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && rd_avail) |=> rd_valid);
   // R8: no word appears without a granted read
   a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_en && rd_avail) |=> !rd_valid);
   // R6: drop count moves by at most one per cycle
   a_r6_drop_step: assert property (@(posedge clk) disable iff (!rst_n)
      (drop_count == $past(drop_count)) || (drop_count == $past(drop_count) + 1'b1));
   // R9: an idle input cycle changes neither drops nor committed data
   a_r9_idle_inert: assert property (@(posedge clk) disable iff (!rst_n)
      !s_valid |=> ($stable(drop_count) && $stable(cm_ptr)));
endmodule

bind zs_snippet_buf zs_snippet_buf_chk #(.AW(AW), .DEPTH(DEPTH), .DROP_W(DROP_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .rd_en(rd_en), .rd_avail(rd_avail),
   .rd_valid(rd_valid), .drop_count(drop_count), .wr_ptr(wr_ptr), .cm_ptr(cm_ptr),
   .rd_ptr(rd_ptr));

// File: tb/zs_snippet_buf_test.sv
module zs_snippet_buf_test;
   localparam int SW = 12, TSW = 24, NPRE = 3, NPOST = 2, MAXL = 12, DEP = 16, PK = 3;
   localparam int WW = PK * SW, LW = $clog2(MAXL + 1), WORST = 1 + (MAXL + PK - 1) / PK;
   localparam int DW = 16;

   logic clk = 0, rst_n = 0, s_valid = 0, rd_en = 0;
   logic [SW-1:0] thresh = 12'd100, s_data = '0;
   logic [TSW-1:0] s_ts = '0;
   logic rd_avail, rd_valid;
   logic [WW-1:0] rd_data;
   logic [DW-1:0] drop_count;

   always #2 clk = ~clk;

   zs_snippet_buf #(.SAMPLE_W(SW), .TS_W(TSW), .PACK(PK), .N_PRE(NPRE), .N_POST(NPOST),
                    .MAX_LEN(MAXL), .DEPTH(DEP), .DROP_W(DW)) uut (
      .clk(clk), .rst_n(rst_n), .thresh(thresh), .s_valid(s_valid), .s_data(s_data),
      .s_ts(s_ts), .rd_en(rd_en), .rd_avail(rd_avail), .rd_valid(rd_valid),
      .rd_data(rd_data), .drop_count(drop_count));

   int checks = 0, errors = 0;
   logic [WW-1:0] exp_q[$];
   int xs[$], tss[$];
   int ts_ctr, kdone, m_used, exp_drops;
   bit m_open, m_skip;
   int m_len, m_slot, m_ts0;
   logic [WW-1:0] m_pk;
   logic [WW-1:0] m_dq[$];

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // monitor: pop the scoreboard on every returned word
   always @(negedge clk) begin
      if (rst_n && rd_valid) begin
         if (exp_q.size() == 0) check(0, "R8 unexpected word", rd_data, 0);
         else begin
            logic [WW-1:0] e;
            e = exp_q.pop_front();
            check(rd_data == e, "R2/R3/R4 word", rd_data, e);
         end
      end
   end

   task automatic do_reset();
      rst_n = 0;
      xs.delete(); tss.delete(); exp_q.delete(); m_dq.delete();
      ts_ctr = 5; kdone = 0; m_used = 0; exp_drops = 0;
      m_open = 0; m_skip = 0; m_len = 0; m_slot = 0; m_pk = '0; m_ts0 = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
   endtask

   // driver: one sample then gap idle cycles carrying garbage (R9)
   task automatic send(input int val, input int gap);
      s_valid = 1; s_data = SW'(val); s_ts = TSW'(ts_ctr);
      xs.push_back(val); tss.push_back(ts_ctr); ts_ctr++;
      @(negedge clk);
      s_valid = 0; s_data = '1; s_ts = '1;
      repeat (gap) @(negedge clk);
   endtask

   task automatic lows(input int n);
      for (int i = 0; i < n; i++) send(20 + (i % 50), i % 3);
   endtask

   task automatic m_close(input bit trunc);
      logic [WW-1:0] h;
      if (m_slot != 0) m_dq.push_back(m_pk);
      if (!m_skip) begin
         h = '0;
         h[TSW-1:0] = TSW'(m_ts0);
         h[TSW +: LW] = LW'(m_len);
         h[TSW + LW] = trunc;
         exp_q.push_back(h);
         foreach (m_dq[i]) exp_q.push_back(m_dq[i]);
         m_used += 1 + m_dq.size();
      end
      m_dq.delete(); m_open = 0;
   endtask

   // scoreboard model built from the window definition of R2
   task automatic build();
      for (int k = kdone; k < xs.size(); k++) begin
         int j, val, t;
         bit kept;
         j = k - NPRE;
         val = (j < 0) ? 0 : xs[j];
         t = (j < 0) ? 0 : tss[j];
         kept = 0;
         for (int i = j - NPOST; i <= j + NPRE; i++)
            if (i >= 0 && xs[i] >= int'(thresh)) kept = 1;
         if (kept) begin
            if (!m_open) begin
               m_open = 1; m_len = 0; m_slot = 0; m_pk = '0; m_ts0 = t;
               m_skip = (DEP - m_used) < WORST;
               if (m_skip) exp_drops++;
            end
            m_pk = m_pk | (WW'(val) << (SW * m_slot));
            m_len++; m_slot++;
            if (m_slot == PK) begin m_dq.push_back(m_pk); m_pk = '0; m_slot = 0; end
            if (m_len == MAXL) m_close(1);
         end else if (m_open) m_close(0);
      end
      kdone = xs.size();
   endtask

   task automatic drain(input string req);
      while (rd_avail) begin
         rd_en = 1;
         @(negedge clk);
      end
      rd_en = 0;
      @(negedge clk);
      check(exp_q.size() == 0, req, exp_q.size(), 0);
      m_used = 0;
   endtask

   initial begin
      #(4 * 150000);
      errors++; checks++;
      $display("FAIL R10 watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      do_reset();
      // R10 reset state
      check(rd_avail == 0, "R10 rd_avail", rd_avail, 0);
      check(rd_valid == 0, "R10 rd_valid", rd_valid, 0);
      check(drop_count == 0, "R10 drop_count", drop_count, 0);

      // R1: 99 does not trigger, exactly 100 does; R7: not visible while open
      lows(8); send(99, 1); lows(6);
      check(rd_avail == 0, "R1 below-threshold no snippet", rd_avail, 0);
      send(100, 0); send(30, 1);
      check(rd_avail == 0, "R7 open snippet hidden", rd_avail, 0);
      lows(8);
      build();
      check(exp_q.size() == 3, "R1 snippet words", exp_q.size(), 3);
      check(rd_avail == 1, "R7 visible after close", rd_avail, 1);
      drain("R8 single snippet drained");

      // R8: read requests while empty are ignored
      rd_en = 1; repeat (3) @(negedge clk); rd_en = 0;
      check(rd_valid == 0, "R8 empty read ignored", rd_valid, 0);

      // R2/R3: merged crossings with padded tail, then a separate one
      send(300, 0); lows(4); send(400, 2); lows(10);
      send(4095, 1); lows(9);
      build();
      drain("R2 merge and split");

      // R2: crossing right after reset, look-back is zeros at ts 0
      do_reset();
      send(500, 0); lows(8);
      build();
      check(exp_q.size() > 0 && exp_q[0][TSW-1:0] == 0, "R2 pre-reset history ts",
            exp_q.size() > 0 ? exp_q[0][TSW-1:0] : 1, 0);
      drain("R2 early crossing");

      // R5: long run truncates and continues
      for (int i = 0; i < 20; i++) send(200 + i, i % 2);
      lows(9);
      build();
      drain("R5 truncated snippets");

      // R6: fill without reading, drops counted, then recovery
      do_reset();
      for (int p = 0; p < 6; p++) begin send(700 + p, 0); lows(9); end
      build();
      check(drop_count == DW'(exp_drops), "R6 drop count", drop_count, exp_drops);
      check(exp_drops == 2, "R6 expected drops", exp_drops, 2);
      drain("R6 kept snippets intact");
      send(800, 1); lows(9);
      build();
      check(exp_q.size() == 3, "R6 stored after space freed", exp_q.size(), 3);
      drain("R6 recovery");
      check(drop_count == 2, "R6 drop count steady", drop_count, 2);

      // R9: long idle with garbage on the inputs
      s_data = '1; repeat (20) @(negedge clk);
      check(rd_avail == 0, "R9 idle ignored", rd_avail, 0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule